// File: doc/BRIEF.md
# Two-Queue Conversion Command Sequencer

This block drives an external analog converter from a 64-entry table of conversion command words. Each word names one input channel, a sample-time code and an amplifier-bypass bit. The table holds either one queue or two. In two-queue mode a programmable start index gives where the second queue begins, and the first queue occupies the entries below it. A trigger starts a queue. The sequencer then issues the commands one at a time over a start-conversion / end-of-conversion handshake. Each returned result goes into a 64-entry result table, at the same index as the command that produced it.

A pause bit on a command word ends a subqueue once that command has converted. The queue then waits, and its next trigger resumes it at the following entry. Queue 1 takes precedence over queue 2. Queue 2 only yields between commands, and it later continues from its first unexecuted entry. Each queue also has a continuous mode, in which reaching the end restarts it without a new trigger.

Top module: `cmdq_sequencer`

## Requirements
- R1: After reset, conv_start is low, all pause and done flags are low, and every result table entry reads 0.
- R2: Command word fields are: bits 5:0 channel, bits 7:6 sample-time code, bit 8 bypass, bit 9 pause. Each command is issued as a one-cycle conv_start pulse, with conv_chan, conv_ist and conv_byp carrying that word's fields.
- R3: On conv_eoc during an outstanding conversion, conv_result is written to the result table at the command's index. conv_eoc while no conversion is outstanding changes nothing.
- R4: A command whose channel field is 63 ends its queue without being converted, and it sets that queue's done flag (q_done bit 0 = queue 1, bit 1 = queue 2).
- R5: With queue 2 disabled, queue 1 runs from index 0 through to an end marker or index 63, whatever the stored queue-2 start index, and trig_q2 has no effect.
- R6: With queue 2 enabled at start index S, queue 1 runs from index 0 and ends before S. Queue 2 runs from S to an end marker or index 63.
- R7: A command with the pause bit set is converted. Its queue then sets its q_paused bit and waits. The next trigger clears the flag and resumes at the following entry.
- R8: If both queues are runnable, queue 1 commands are issued first. A running queue 2 is suspended only between commands, and it resumes at its next unexecuted entry once queue 1 finishes or pauses.
- R9: A trigger to a queue that is running is ignored. A trigger to a finished or idle queue clears its done flag and restarts it at its first entry.
- R10: In continuous mode (control bit 0 = 1), reaching the end sets the done flag and restarts the queue at its first entry without a trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 = command table, 1 = queue 1 control, 2 = queue 2 control |
| cfg_addr | input | 6 | Table index, or queue 2 start index when cfg_sel = 2 |
| cfg_wdata | input | 10 | Command word, or control bits (bit 0 continuous, bit 1 queue 2 enable) |
| trig_q1 | input | 1 | Trigger for queue 1 |
| trig_q2 | input | 1 | Trigger for queue 2 |
| conv_chan | output | 6 | Channel of the current conversion |
| conv_ist | output | 2 | Sample-time code of the current conversion |
| conv_byp | output | 1 | Amplifier bypass of the current conversion |
| conv_start | output | 1 | One-cycle start-conversion pulse |
| conv_eoc | input | 1 | End-of-conversion from the converter |
| conv_result | input | 10 | Conversion result, valid with conv_eoc |
| rd_addr | input | 6 | Result table read index |
| rd_data | output | 10 | Result table read data |
| q_paused | output | 2 | Per-queue pause flags |
| q_done | output | 2 | Per-queue completion flags |

## Verification
The case that matters most is a queue 1 trigger that arrives in the same cycle as the end-of-conversion of a queue 2 command. In that cycle the result must be stored, queue 2's pointer must advance, and queue 1 must become runnable, all at once. The bench waits for the converter stub's end-of-conversion edge and raises trig_q1 in that same cycle. It then compares the logged channel order against the expected one: first the single queue 2 command, then the whole of queue 1, then the rest of queue 2. It also reads back the result table to confirm that nothing was lost or stored at the wrong index.

// File: rtl/cmdq_pkg.sv
// Shared types for the conversion command sequencer.
// Assumes: two queues; field positions of the command word are derived
// from the table address width in the top module.
package cmdq_pkg;
    typedef enum logic [1:0] {
        Q_IDLE  = 2'd0,
        Q_RUN   = 2'd1,
        Q_PAUSE = 2'd2
    } qstate_t;

    typedef enum logic {
        E_IDLE = 1'b0,
        E_WAIT = 1'b1
    } estate_t;

    localparam int NUM_QUEUES = 2;
endpackage

// File: rtl/cmdq_table.sv
// Register-array table with one write port and one asynchronous read port.
// Assumes: entries clear to zero on reset; a write is visible on the next cycle.
module cmdq_table #(
    parameter int AW = 6,
    parameter int W  = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    // Storage: clear on reset, otherwise write the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read path.
    assign rdata = mem[raddr];
endmodule

// File: rtl/cmdq_queue_ctl.sv
// Per-queue control: run state, command pointer, pause and done flags.
// Assumes: the engine raises adv or end_hit only while this queue is running,
// so triggers (acted on only when not running) never collide with it.
module cmdq_queue_ctl
    import cmdq_pkg::*;
#(
    parameter int PW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig,
    input  logic          allowed,
    input  logic          continuous,
    input  logic [PW-1:0] start_ptr,
    input  logic          adv,
    input  logic          pause_hit,
    input  logic          end_hit,
    output logic          active,
    output logic [PW-1:0] ptr,
    output logic          paused,
    output logic          done
);
    qstate_t st;

    // Queue state update: engine events while running, triggers otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= Q_IDLE;
            ptr    <= '0;
            paused <= 1'b0;
            done   <= 1'b0;
        end else if (st == Q_RUN) begin
            if (end_hit) begin
                done <= 1'b1;
                if (continuous) ptr <= start_ptr;
                else            st  <= Q_IDLE;
            end else if (adv) begin
                ptr <= ptr + 1'b1;
                if (pause_hit) begin
                    st     <= Q_PAUSE;
                    paused <= 1'b1;
                end
            end
        end else if (trig && allowed) begin
            st     <= Q_RUN;
            paused <= 1'b0;
            if (st == Q_IDLE) begin
                ptr  <= start_ptr;
                done <= 1'b0;
            end
        end
    end

    // Runnable indication for the engine.
    assign active = (st == Q_RUN);

    assert_pause_after_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(paused) |-> $past(adv && pause_hit));

    assert_done_on_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(end_hit));

    assert_trig_ignored_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && trig && !adv && !end_hit) |=> ($stable(ptr) && active));
endmodule

// File: rtl/cmdq_sequencer.sv
// Two-queue conversion command sequencer (top).
// Assumes: one conversion outstanding at a time; conv_eoc is only meaningful
// after a conv_start; queue 1 wins whenever both queues are runnable.
module cmdq_sequencer
    import cmdq_pkg::*;
#(
    parameter int AW = 6,
    parameter int RW = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_sel,
    input  logic [AW-1:0]   cfg_addr,
    input  logic [AW+3:0]   cfg_wdata,
    input  logic            trig_q1,
    input  logic            trig_q2,
    output logic [AW-1:0]   conv_chan,
    output logic [1:0]      conv_ist,
    output logic            conv_byp,
    output logic            conv_start,
    input  logic            conv_eoc,
    input  logic [RW-1:0]   conv_result,
    input  logic [AW-1:0]   rd_addr,
    output logic [RW-1:0]   rd_data,
    output logic [1:0]      q_paused,
    output logic [1:0]      q_done
);
    localparam int CW    = AW + 4;
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam int F_IST = AW;
    localparam int F_BYP = AW + 2;
    localparam int F_PAU = AW + 3;
    localparam logic [PW-1:0] FULL = PW'(DEPTH);

    // Configuration registers.
    logic          cont_q1, cont_q2, q2_en;
    logic [AW-1:0] q2_start;

    // Per-queue signals.
    logic [NUM_QUEUES-1:0] q_active, q_adv, q_end, q_trig, q_allow, q_cont;
    logic [PW-1:0]         q_ptr   [NUM_QUEUES];
    logic [PW-1:0]         q_start [NUM_QUEUES];
    logic [PW-1:0]         q_lim   [NUM_QUEUES];

    // Engine state.
    estate_t       est;
    logic          run_q;
    logic [AW-1:0] run_idx;
    logic          run_pause;

    logic          sel, sel_ok, at_end, issue, eoc_take;
    logic [PW-1:0] cur_ptr;
    logic [CW-1:0] word;

    // Queue control register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cont_q1  <= 1'b0;
            cont_q2  <= 1'b0;
            q2_en    <= 1'b0;
            q2_start <= '0;
        end else if (cfg_we && cfg_sel == 2'd1) begin
            cont_q1 <= cfg_wdata[0];
        end else if (cfg_we && cfg_sel == 2'd2) begin
            cont_q2  <= cfg_wdata[0];
            q2_en    <= cfg_wdata[1];
            q2_start <= cfg_addr;
        end
    end

    cmdq_table #(.AW(AW), .W(CW)) u_cmd (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we && cfg_sel == 2'd0),
        .waddr (cfg_addr),
        .wdata (cfg_wdata),
        .raddr (cur_ptr[AW-1:0]),
        .rdata (word)
    );

    cmdq_table #(.AW(AW), .W(RW)) u_res (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (eoc_take),
        .waddr (run_idx),
        .wdata (conv_result),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // Queue geometry: queue 1 from 0 up to queue 2 start (or full table).
    assign q_start[0] = '0;
    assign q_start[1] = {1'b0, q2_start};
    assign q_lim[0]   = q2_en ? {1'b0, q2_start} : FULL;
    assign q_lim[1]   = FULL;
    assign q_allow    = {q2_en, 1'b1};
    assign q_trig     = {trig_q2, trig_q1};
    assign q_cont     = {cont_q2, cont_q1};

    generate
        for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_queue
            cmdq_queue_ctl #(.PW(PW)) u_ctl (
                .clk        (clk),
                .rst_n      (rst_n),
                .trig       (q_trig[q]),
                .allowed    (q_allow[q]),
                .continuous (q_cont[q]),
                .start_ptr  (q_start[q]),
                .adv        (q_adv[q]),
                .pause_hit  (run_pause),
                .end_hit    (q_end[q]),
                .active     (q_active[q]),
                .ptr        (q_ptr[q]),
                .paused     (q_paused[q]),
                .done       (q_done[q])
            );
            assign q_adv[q] = eoc_take && (run_q == 1'(q));
            assign q_end[q] = (est == E_IDLE) && sel_ok && (sel == 1'(q)) && at_end;
        end
    endgenerate

    // Queue selection and end detection for the next command.
    always_comb begin
        sel_ok   = |q_active;
        sel      = !q_active[0];
        cur_ptr  = q_ptr[sel];
        at_end   = (cur_ptr >= q_lim[sel]) || (&word[AW-1:0]);
        issue    = (est == E_IDLE) && sel_ok && !at_end;
        eoc_take = (est == E_WAIT) && conv_eoc;
    end

    // Engine: issue one command, then wait for its end-of-conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            est        <= E_IDLE;
            run_q      <= 1'b0;
            run_idx    <= '0;
            run_pause  <= 1'b0;
            conv_chan  <= '0;
            conv_ist   <= '0;
            conv_byp   <= 1'b0;
            conv_start <= 1'b0;
        end else begin
            conv_start <= 1'b0;
            if (issue) begin
                est        <= E_WAIT;
                run_q      <= sel;
                run_idx    <= cur_ptr[AW-1:0];
                run_pause  <= word[F_PAU];
                conv_chan  <= word[AW-1:0];
                conv_ist   <= word[F_IST+1:F_IST];
                conv_byp   <= word[F_BYP];
                conv_start <= 1'b1;
            end else if (eoc_take) begin
                est <= E_IDLE;
            end
        end
    end

    assert_start_single_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    assert_q1_precedence_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && run_q) |-> !$past(q_active[0]));

    assert_no_issue_while_waiting_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (est == E_WAIT && !conv_eoc) |=> !conv_start);

    assert_issue_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && !run_q && q2_en) |-> (run_idx < q2_start));
endmodule

// File: tb/sim_cmdq_sequencer.sv
module sim_cmdq_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [5:0] cfg_addr = '0;
    logic [9:0] cfg_wdata = '0;
    logic       trig_q1 = 1'b0, trig_q2 = 1'b0;
    logic [5:0] conv_chan;
    logic [1:0] conv_ist;
    logic       conv_byp, conv_start;
    logic       stub_eoc = 1'b0, man_eoc = 1'b0;
    logic [9:0] stub_res = '0, man_res = '0;
    logic [5:0] rd_addr = '0;
    logic [9:0] rd_data;
    logic [1:0] q_paused, q_done;

    int n_tests = 0, n_fail = 0;
    int log_n = 0;
    logic [5:0] log_chan [0:511];
    int cnt = 0;
    logic [9:0] pend = '0;

    always #5 clk = ~clk;

    cmdq_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .trig_q1(trig_q1),
        .trig_q2(trig_q2), .conv_chan(conv_chan), .conv_ist(conv_ist),
        .conv_byp(conv_byp), .conv_start(conv_start),
        .conv_eoc(stub_eoc | man_eoc), .conv_result(stub_res | man_res),
        .rd_addr(rd_addr), .rd_data(rd_data), .q_paused(q_paused), .q_done(q_done)
    );

    // Converter stub: result encodes {chan, ist, byp, 1}; eoc 3 cycles after start.
    always @(negedge clk) begin
        if (stub_eoc) begin stub_eoc = 1'b0; stub_res = '0; end
        if (cnt != 0) begin
            cnt = cnt - 1;
            if (cnt == 0) begin stub_eoc = 1'b1; stub_res = pend; end
        end
        if (conv_start) begin
            if (log_n < 512) log_chan[log_n] = conv_chan;
            log_n = log_n + 1;
            pend = {conv_chan, conv_ist, conv_byp, 1'b1};
            cnt = 3;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [1:0] s, input logic [5:0] a, input logic [9:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_cmd(input int idx, input bit pau, input bit byp, input int ist, input int ch);
        wr_cfg(2'd0, 6'(idx), {pau, byp, 2'(ist), 6'(ch)});
    endtask

    task automatic pulse(input bit t1, input bit t2);
        @(negedge clk);
        trig_q1 = t1; trig_q2 = t2;
        @(negedge clk);
        trig_q1 = 1'b0; trig_q2 = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [9:0] enc(input int ch, input int ist, input bit byp);
        return {6'(ch), 2'(ist), byp, 1'b1};
    endfunction

    task automatic read_res(input int idx, output logic [9:0] v);
        @(negedge clk);
        rd_addr = 6'(idx);
        #1 v = rd_data;
    endtask

    task automatic check_log(input int base, input int exp[], input string req);
        check(log_n - base == exp.size(), req, log_n - base, exp.size());
        foreach (exp[i])
            if (base + i < log_n)
                check(log_chan[base + i] == 6'(exp[i]), req, log_chan[base + i], exp[i]);
    endtask

    // Queue 1 channels 10..17 at 0..7, queue 2: 40,41,42,end at 8..11.
    task automatic load_two_queue();
        for (int i = 0; i < 8; i++) wr_cmd(i, 0, i[0], i % 4, 10 + i);
        wr_cmd(8, 0, 0, 0, 40);
        wr_cmd(9, 0, 1, 1, 41);
        wr_cmd(10, 0, 0, 2, 42);
        wr_cmd(11, 0, 0, 0, 63);
        wr_cfg(2'd2, 6'd8, 10'b10);
    endtask

    task automatic t_reset();
        logic [9:0] v;
        check(conv_start == 1'b0, "R1 conv_start", conv_start, 0);
        check(q_done == 2'b00 && q_paused == 2'b00, "R1 flags", {q_done, q_paused}, 0);
        read_res(0, v);  check(v == 0, "R1 result0", v, 0);
        read_res(37, v); check(v == 0, "R1 result37", v, 0);
    endtask

    task automatic t_single();
        logic [9:0] v;
        int base;
        wr_cfg(2'd2, 6'd2, 10'b00);
        wr_cmd(0, 0, 1, 2, 5);
        wr_cmd(1, 0, 0, 1, 9);
        wr_cmd(2, 0, 0, 3, 33);
        wr_cmd(3, 0, 1, 1, 63);
        base = log_n;
        pulse(1, 0);
        settle(40);
        check_log(base, '{5, 9, 33}, "R5 single queue spans start index");
        check(q_done == 2'b01, "R4 done q1 only", q_done, 1);
        read_res(0, v); check(v == enc(5, 2, 1), "R2 fields idx0", v, enc(5, 2, 1));
        read_res(1, v); check(v == enc(9, 1, 0), "R3 result idx1", v, enc(9, 1, 0));
        read_res(2, v); check(v == enc(33, 3, 0), "R2 fields idx2", v, enc(33, 3, 0));
        read_res(3, v); check(v == 0, "R4 end entry not converted", v, 0);
        base = log_n;
        pulse(0, 1);
        settle(30);
        check(log_n == base && q_done == 2'b01, "R5 trig_q2 ignored", log_n - base, 0);
    endtask

    task automatic t_stray_eoc();
        logic [9:0] v;
        @(negedge clk);
        man_eoc = 1'b1; man_res = 10'h3FF;
        @(negedge clk);
        man_eoc = 1'b0; man_res = '0;
        settle(3);
        read_res(0, v); check(v == enc(5, 2, 1), "R3 stray eoc idx0", v, enc(5, 2, 1));
        check(conv_start == 1'b0 && q_done == 2'b01, "R3 stray eoc no action", q_done, 1);
    endtask

    task automatic t_two_queue();
        logic [9:0] v;
        int base;
        load_two_queue();
        base = log_n;
        pulse(1, 0);
        settle(80);
        check_log(base, '{10, 11, 12, 13, 14, 15, 16, 17}, "R6 queue1 stops before start");
        base = log_n;
        pulse(0, 1);
        settle(40);
        check_log(base, '{40, 41, 42}, "R6 queue2 from start");
        check(q_done == 2'b11, "R6 both done", q_done, 3);
        read_res(9, v); check(v == enc(41, 1, 1), "R6 result idx9", v, enc(41, 1, 1));
    endtask

    task automatic t_pause();
        int base;
        wr_cmd(9, 1, 1, 1, 41);
        base = log_n;
        pulse(0, 1);
        settle(50);
        check_log(base, '{40, 41}, "R7 subqueue stops after pause entry");
        check(q_paused == 2'b10 && q_done[1] == 1'b0, "R7 pause flag", {q_paused, q_done}, 4'b1001);
        base = log_n;
        pulse(0, 1);
        settle(30);
        check_log(base, '{42}, "R7 resume after pause");
        check(q_paused == 2'b00 && q_done[1] == 1'b1, "R7 resume done", {q_paused, q_done}, 4'b0011);
        wr_cmd(9, 0, 1, 1, 41);
    endtask

    task automatic t_both();
        int base;
        base = log_n;
        pulse(1, 1);
        settle(120);
        check_log(base, '{10, 11, 12, 13, 14, 15, 16, 17, 40, 41, 42}, "R8 queue1 first");
    endtask

    task automatic t_preempt();
        logic [9:0] v;
        int base;
        base = log_n;
        pulse(0, 1);
        @(posedge stub_eoc);
        trig_q1 = 1'b1;
        @(negedge clk);
        trig_q1 = 1'b0;
        settle(120);
        check_log(base, '{40, 10, 11, 12, 13, 14, 15, 16, 17, 41, 42}, "R8 preempt at boundary");
        read_res(8, v); check(v == enc(40, 0, 0), "R8 result kept on coincident trig", v, enc(40, 0, 0));
    endtask

    task automatic t_retrig();
        int base;
        base = log_n;
        pulse(1, 0);
        settle(2);
        check(q_done[0] == 1'b0, "R9 restart clears done", q_done[0], 0);
        settle(10);
        pulse(1, 0);
        settle(80);
        check(log_n - base == 8, "R9 trigger while running ignored", log_n - base, 8);
        check(q_done[0] == 1'b1, "R9 done again", q_done[0], 1);
    endtask

    task automatic t_continuous();
        int base, n_stop;
        wr_cfg(2'd2, 6'd8, 10'b11);
        base = log_n;
        pulse(0, 1);
        settle(45);
        check(log_n - base >= 6, "R10 continuous repeats", log_n - base, 6);
        if (log_n - base >= 6)
            check(log_chan[base + 3] == 6'd40 && log_chan[base + 5] == 6'd42,
                  "R10 restart at first entry", log_chan[base + 3], 40);
        wr_cfg(2'd2, 6'd8, 10'b10);
        settle(40);
        n_stop = log_n;
        settle(40);
        check(log_n == n_stop, "R10 stops once cleared", log_n - n_stop, 0);
        check(log_chan[log_n - 1] == 6'd42 && q_done[1] == 1'b1, "R10 done at end",
              log_chan[log_n - 1], 42);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        settle(3);
        rst_n = 1'b1;
        settle(2);
        t_reset();
        t_single();
        t_stray_eoc();
        t_two_queue();
        t_pause();
        t_both();
        t_preempt();
        t_retrig();
        t_continuous();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule